// File: doc/BRIEF.md
# Sixteen-bit timer on a byte-wide bus

This block is a free-running up-counter with a matching compare register. It is reached through an 8-bit data bus. A single-cycle count-enable input, `tick`, advances the counter. Software reads and writes the counter, the compare register and a small control/status byte with single-cycle read and write strobes.

In wide mode the counter and the compare register act as 16-bit quantities. A shared byte-wide holding register keeps each 16-bit value coherent across two bus accesses. The upper byte is always accessed first and the lower byte next. In split mode the same storage acts as two unrelated 8-bit counters, each with its own 8-bit compare value and its own match flag. In this mode every byte is reached directly, in any order, and the holding register is left alone.

A match flag is raised when a counter equals its compare value. It stays raised until software writes 0 to it.

Top module: `byte_bus_timer16`

## Requirements
- R1: After reset the counter is 0x0000, the compare register is 0xFFFF, the holding register is 0x00, wide mode is selected and both match flags are 0.
- R2: In wide mode each cycle with `tick`=1 adds one to the 16-bit counter, wrapping from 0xFFFF to 0x0000. A cycle with `tick`=0 and no counter write leaves the counter unchanged.
- R3: In wide mode, reading address 0 returns the live counter bits 15:8 and, at the same clock edge, copies counter bits 7:0 into the holding register. Reading address 1 returns the holding register, whatever the counter has done since.
- R4: In wide mode, writing address 0 or 2 stores the byte only in the holding register; the counter and the compare register are unchanged. Writing address 1 loads the counter, and writing address 3 loads the compare register, with {holding, written byte} in a single edge. A lone lower-byte write therefore uses whatever byte the holding register last held.
- R5: Address map. Address 0 is counter bits 15:8, address 1 is counter bits 7:0, address 2 is compare bits 15:8, address 3 is compare bits 7:0, and address 4 is control/status. Addresses 5 to 7 read 0x00, and writes to them have no effect.
- R6: In split mode (control bit 0 = 1), addresses 0 to 3 read and write their byte directly, in any order. The holding register is neither written nor read: a lower-byte write after a return to wide mode still uses the byte it held before split mode.
- R7: In split mode each `tick` adds one to bits 7:0 and to bits 15:8 separately. Each half wraps from 0xFF to 0x00 with no carry into the other.
- R8: Match flag A (status bit 1) is set one edge after a cycle in which the counter equals the compare register in wide mode, or the low bytes are equal in split mode. It then stays set. Match flag B (status bit 2) is set the same way by equal high bytes, and only in split mode.
- R9: Writing address 4 sets the mode from data bit 0. It clears flag A when data bit 1 is 0 and flag B when data bit 2 is 0; a 1 in either bit leaves that flag unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R10: Reading address 4 returns {5'b0, flag B, flag A, mode}. The outputs `match_a` and `match_b` always show the two flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one cycle per count |
| rd | input | 1 | Read strobe for the addressed byte |
| wr | input | 1 | Write strobe for the addressed byte |
| addr | input | 3 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address (combinational) |
| match_a | output | 1 | Match flag A |
| match_b | output | 1 | Match flag B |

## Verification
The bench lets the counter run between an upper-byte read and the lower-byte read that follows it. A design that returned the live low byte instead of the captured one would give a torn value. It preloads the counter near the boundaries 0x00FF, 0xFFFF and, in split mode, 0xFF in the low half. These catch a missing wrap and a carry that leaks from one half into the other in split mode. It also places the holding register in a known state before split mode and makes a lone lower-byte write after returning to wide mode, so a design that let split-mode traffic touch the holding register loads the wrong upper byte. It clears a flag during an ongoing match to expose the wrong priority between setting and clearing.

// File: rtl/byte_bus_timer16.sv
module byte_bus_timer16 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rd,
  input  logic       wr,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       match_a,
  output logic       match_b
);

  logic [15:0] cnt, cmp, cnt_nx, cmp_nx;
  logic [7:0]  hold;
  logic        split, flag_a, flag_b;

  wire w0 = wr && addr == 3'd0;
  wire w1 = wr && addr == 3'd1;
  wire w2 = wr && addr == 3'd2;
  wire w3 = wr && addr == 3'd3;
  wire w4 = wr && addr == 3'd4;
  wire r0 = rd && !wr && addr == 3'd0;

  wire cnt_wr = w1 || (w0 && split);
  wire hit_a  = split ? (cnt[7:0] == cmp[7:0]) : (cnt == cmp);
  wire hit_b  = split && (cnt[15:8] == cmp[15:8]);

  always_comb begin
    cnt_nx = cnt;
    if (tick) cnt_nx = split ? {cnt[15:8] + 8'd1, cnt[7:0] + 8'd1} : cnt + 16'd1;
    if (w0 && split) cnt_nx[15:8] = wdata;
    if (w1) cnt_nx = split ? {cnt_nx[15:8], wdata} : {hold, wdata};
  end

  always_comb begin
    cmp_nx = cmp;
    if (w2 && split) cmp_nx[15:8] = wdata;
    if (w3) cmp_nx = split ? {cmp[15:8], wdata} : {hold, wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= 16'h0000;
      cmp    <= 16'hFFFF;
      hold   <= 8'h00;
      split  <= 1'b0;
      flag_a <= 1'b0;
      flag_b <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      cmp <= cmp_nx;
      if (!split && (w0 || w2)) hold <= wdata;
      else if (!split && r0)    hold <= cnt[7:0];
      if (w4) split <= wdata[0];
      flag_a <= (flag_a && !(w4 && !wdata[1])) || hit_a;
      flag_b <= (flag_b && !(w4 && !wdata[2])) || hit_b;
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = cnt[15:8];
      3'd1:    rdata = split ? cnt[7:0] : hold;
      3'd2:    rdata = cmp[15:8];
      3'd3:    rdata = cmp[7:0];
      3'd4:    rdata = {5'b0, flag_b, flag_a, split};
      default: rdata = 8'h00;
    endcase
  end

  assign match_a = flag_a;
  assign match_b = flag_b;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !split && !cnt_wr) |=> cnt == 16'($past(cnt) + 16'd1));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt));
  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (r0 && !split) |=> hold == $past(cnt[7:0]));
  assert_upper_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((w0 || w2) && !split) |=> $stable(cmp));
  assert_no_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && split && !cnt_wr) |=> cnt[15:8] == 8'($past(cnt[15:8]) + 8'd1));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_a && !w4) |=> flag_a);
  assert_b_wide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_b && !split) |=> !flag_b);

endmodule

// File: tb/tb_byte_bus_timer16.sv
`timescale 1ns/1ps
module tb_byte_bus_timer16;
  logic clk = 0, rst_n = 0, tick = 0, rd = 0, wr = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic match_a, match_b;
  int total = 0, bad = 0;

  int m_cnt, m_cmp, m_hold, m_split, m_fa, m_fb;

  byte_bus_timer16 dut (.clk(clk), .rst_n(rst_n), .tick(tick), .rd(rd), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .match_a(match_a), .match_b(match_b));

  always #2 clk = ~clk;

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int model_read(input int a);
    case (a)
      0: return (m_cnt >> 8) & 255;
      1: return m_split ? (m_cnt & 255) : m_hold;
      2: return (m_cmp >> 8) & 255;
      3: return m_cmp & 255;
      4: return (m_fb << 2) | (m_fa << 1) | m_split;
      default: return 0;
    endcase
  endfunction

  task automatic model_step(input bit s_rd, input bit s_wr, input int a, input int d, input bit tk);
    int c = m_cnt, p = m_cmp, h = m_hold, sp = m_split;
    int lo = c & 255, hi = (c >> 8) & 255;
    int sa = sp ? ((c & 255) == (p & 255)) : (c == p);
    int sb = sp && (((c >> 8) & 255) == ((p >> 8) & 255));
    if (tk) begin
      if (sp) m_cnt = (((hi + 1) & 255) << 8) | ((lo + 1) & 255);
      else    m_cnt = (c + 1) & 65535;
    end
    if (s_wr) begin
      case (a)
        0: if (sp) m_cnt = (d << 8) | (m_cnt & 255); else m_hold = d;
        1: if (sp) m_cnt = (m_cnt & 65280) | d; else m_cnt = (h << 8) | d;
        2: if (sp) m_cmp = (d << 8) | (p & 255); else m_hold = d;
        3: if (sp) m_cmp = (p & 65280) | d; else m_cmp = (h << 8) | d;
        4: begin
          m_split = d & 1;
          if (!((d >> 1) & 1)) m_fa = 0;
          if (!((d >> 2) & 1)) m_fb = 0;
        end
        default: ;
      endcase
    end else if (s_rd && a == 0 && !sp) m_hold = lo;
    if (sa) m_fa = 1;
    if (sb) m_fb = 1;
  endtask

  task automatic check(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit s_rd, input bit s_wr, input int a, input int d, input bit tk, input string tag);
    rd = s_rd; wr = s_wr; addr = a[2:0]; wdata = d[7:0]; tick = tk;
    #1;
    if (s_rd) check(tag, rdata, model_read(a), $sformatf("read addr %0d", a));
    check(tag, {match_b, match_a}, (m_fb << 1) | m_fa, "flags");
    @(posedge clk);
    model_step(s_rd, s_wr, a, d, tk);
    @(negedge clk);
    rd = 0; wr = 0; tick = 0;
  endtask

  task automatic rdb(input int a, input string tag); cyc(1, 0, a, 0, 0, tag); endtask
  task automatic wrb(input int a, input int d, input string tag); cyc(0, 1, a, d, 0, tag); endtask
  task automatic run(input int n, input bit tk, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, tk, tag);
  endtask

  initial begin
    m_cnt = 0; m_cmp = 65535; m_hold = 0; m_split = 0; m_fa = 0; m_fb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rdb(4, "R1"); rdb(2, "R1"); rdb(3, "R1"); rdb(0, "R1"); rdb(1, "R1");
    // R2 counting
    run(5, 1, "R2"); rdb(0, "R2"); rdb(1, "R2");
    // R3 coherent read across a moving counter
    wrb(0, 8'h00, "R4"); wrb(1, 8'hFE, "R4");
    rdb(0, "R3"); cyc(1, 0, 1, 0, 1, "R3"); run(4, 1, "R3"); rdb(1, "R3"); rdb(0, "R3");
    // R4 upper write touches only the holding register
    wrb(2, 8'h12, "R4"); rdb(2, "R4"); rdb(3, "R4");
    wrb(3, 8'h34, "R4"); rdb(2, "R4"); rdb(3, "R4");
    // R2 wrap at 0xFFFF
    wrb(0, 8'hFF, "R2"); wrb(1, 8'hFE, "R2"); run(3, 1, "R2"); rdb(0, "R2"); rdb(1, "R2");
    // R8 wide match and stickiness
    wrb(2, 8'h00, "R8"); wrb(3, 8'h10, "R8");
    wrb(0, 8'h00, "R8"); wrb(1, 8'h0C, "R8");
    run(8, 1, "R8"); run(3, 0, "R8"); rdb(4, "R8");
    // R9 clearing rules
    wrb(4, 8'h02, "R9"); rdb(4, "R9");
    wrb(4, 8'h00, "R9"); rdb(4, "R9");
    wrb(0, 8'h00, "R9"); wrb(1, 8'h10, "R9"); run(2, 0, "R9");
    wrb(4, 8'h00, "R9"); rdb(4, "R9");
    wrb(0, 8'h00, "R9"); wrb(1, 8'h20, "R9"); wrb(4, 8'h00, "R9"); rdb(4, "R9");
    // R6 split-mode direct access, holding register preset
    wrb(0, 8'hA5, "R6");
    wrb(4, 8'h01, "R6"); rdb(4, "R10");
    wrb(1, 8'h55, "R6"); wrb(0, 8'h66, "R6"); rdb(1, "R6"); rdb(0, "R6");
    // R7 independent halves
    wrb(0, 8'h10, "R7"); wrb(1, 8'hFE, "R7"); run(3, 1, "R7"); rdb(0, "R7"); rdb(1, "R7");
    // R8 split-mode flags
    wrb(4, 8'h01, "R8"); wrb(3, 8'h05, "R8"); wrb(2, 8'h20, "R8");
    run(6, 1, "R8"); rdb(4, "R10"); run(8, 1, "R8"); rdb(4, "R10");
    wrb(4, 8'h03, "R9"); rdb(4, "R9");
    // R6 back in wide mode: lone lower write uses preserved holding byte
    wrb(4, 8'h00, "R6"); wrb(1, 8'h3C, "R6"); rdb(0, "R6"); rdb(1, "R6");
    // R5 unused addresses
    rdb(5, "R5"); wrb(6, 8'hFF, "R5"); rdb(6, "R5"); rdb(7, "R5"); rdb(4, "R5");
    rdb(2, "R5"); rdb(3, "R5");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule